// File: doc/BRIEF.md
# Width-Expanded Dual-Clock FIFO with Composite Handshake Flags

This block builds one wide first-in first-out buffer from several identical-depth slices placed side by side. Each slice owns one field of the wide word, keeps its own write and read pointers, and carries its pointers across the write-clock/read-clock boundary through its own synchronizer. The synchronizers of different slices may differ in latency, so one slice can raise or drop a handshake flag a cycle after another. The block folds the per-slice flags into one write-side flag and one read-side flag. A transfer is therefore only started when every slice is ready for it.

Two handshake styles are supported, and the mode input is captured while reset is held low. In standard mode the read side reports an active-low empty flag, the write side reports an active-low full flag, and read data appears on the output after the read edge. In first-word-fall-through mode the read side reports an active-low output-ready flag and the head word sits on the output before it is read. The write side reports an active-low input-ready flag. A half-full status is taken from slice 0 alone.

Top module: `wide_fifo`

## Requirements
- R1: During and right after reset the buffer holds no words. In standard mode `empty_or_n`=0 and `full_ir_n`=1. In fall-through mode `empty_or_n`=1 and `full_ir_n`=0. `half_n`=1 and `dout`=0 in both modes.
- R2: `fwft_sel` is sampled only while `rst_n` is low (1 selects fall-through). Changing it after reset has no effect on the flags or on `dout`.
- R3: A write is taken on a `wr_clk` edge only when `wr_en`=1 and the write-side flag shows room. A refused write leaves no word in the buffer, and no slice is ever written while it is full.
- R4: A read is taken on a `rd_clk` edge only when `rd_en`=1 and the read-side flag shows data. In standard mode `dout` holds its value across every edge without a taken read.
- R5: Standard mode: `empty_or_n` goes high (data present) only once every slice holds data. `full_ir_n` is low while any slice is full.
- R6: Fall-through mode: `empty_or_n` goes low (word valid) only once every slice presents its head word. `full_ir_n` is high (no room) while any slice is full.
- R7: `dout` and `din` are the concatenation of the slice fields, with slice 0 in the least significant bits. The default widths are 8, 10 and 12 bits. Words leave in write order and are never assembled from different writes.
- R8: Standard mode: the word read on a `rd_clk` edge is on `dout` after that edge. Fall-through mode: while `empty_or_n`=0, `dout` already holds the oldest word, with no read needed.
- R9: Capacity is 2^`AW` words in standard mode and 2^`AW`+1 words in fall-through mode. The output register adds the extra word.
- R10: `half_n` is low exactly when slice 0 storage, excluding the fall-through output register, holds more than half of 2^`AW` words, as seen from the write side.
- R11: Each slice takes 0 or 1 extra synchronizer stages from `SLICE_LAG`. With mixed lags, R3 to R8 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset, applied in both clock domains |
| fwft_sel | input | 1 | Mode select sampled during reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request |
| din | input | DW (30) | Wide write word |
| rd_en | input | 1 | Read request |
| dout | output | DW (30) | Wide read word |
| full_ir_n | output | 1 | Composite full flag (standard) or input-ready flag (fall-through), active low |
| empty_or_n | output | 1 | Composite empty flag (standard) or output-ready flag (fall-through), active low |
| half_n | output | 1 | Half-full status from slice 0, active low |

## Verification
A write and a read can land in the same cycle while the buffer sits at a boundary. One case is writing into a full buffer while the oldest word leaves. The other is reading from a nearly empty buffer while a first word enters. In both cases the slice with the extra synchronizer stage is still showing the old state. The bench provokes this by running both requests at full rate from the full state and from the empty state, and by running long random mixes of write-heavy, read-heavy and balanced traffic. Each result is judged against a queue model that only advances when the port flag showed readiness. Every output word must match the model exactly, field for field. After traffic stops, the flags must settle to the values the model's word count predicts.

// File: rtl/wide_fifo_pkg.sv
// Shared types and helpers for the width-expanded FIFO.
// Assumes at most 32 slices, each described by an 8-bit width entry.
package wide_fifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // Lowest bit position of field idx, given packed 8-bit slice widths.
    function automatic int field_lo(input logic [255:0] list, input int idx);
        int s;
        s = 0;
        for (int j = 0; j < idx; j++) begin
            s += int'(list[j*8 +: 8]);
        end
        return s;
    endfunction

endpackage

// File: rtl/wide_fifo_gray_sync.sv
// Carries a Gray-coded pointer into another clock domain.
// Two stages are always present; LAG adds more, to model slower crossings.
// Assumes the input changes at most one bit per source clock.
module wide_fifo_gray_sync #(
    parameter int PW  = 5,
    parameter int LAG = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] q
);
    localparam int STAGES = 2 + LAG;

    logic [PW-1:0] pipe [STAGES];

    // Shift the pointer through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/wide_fifo_flag_merge.sv
// Folds per-slice active-low handshake flags into one composite flag.
// Standard mode: a high flag means ready, so AND waits for all slices.
// Fall-through mode: a low flag means ready, so OR waits for all slices.
module wide_fifo_flag_merge
    import wide_fifo_pkg::*;
#(
    parameter int N = 3
) (
    input  fifo_mode_e     mode,
    input  logic [N-1:0]   flags_n,
    output logic           merged_n
);
    // Pick the combine function that only reports ready once all agree.
    always_comb begin
        if (mode == MODE_FWFT) merged_n = |flags_n;
        else                   merged_n = &flags_n;
    end

endmodule

// File: rtl/wide_fifo_slice.sv
// One narrow dual-clock FIFO slice holding one field of the wide word.
// Exports device-style active-low flags whose polarity follows the mode.
// Assumes the parent only strobes wr_en/rd_en when the composite allows it.
module wide_fifo_slice
    import wide_fifo_pkg::*;
#(
    parameter int W   = 8,
    parameter int AW  = 4,
    parameter int LAG = 0
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  fifo_mode_e    mode_w,
    input  fifo_mode_e    mode_r,
    input  logic          wr_en,
    input  logic [W-1:0]  din,
    input  logic          rd_en,
    output logic [W-1:0]  q,
    output logic          wflag_n,
    output logic          rflag_n,
    output logic [AW:0]   wr_level
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_w, wgray_r;
    logic [PW-1:0] wbin_nx, rbin_nx;
    logic          full, ram_empty, ovalid, take;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wide_fifo_gray_sync #(.PW(PW), .LAG(LAG)) u_rd2wr (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w)
    );

    wide_fifo_gray_sync #(.PW(PW), .LAG(LAG)) u_wr2rd (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r)
    );

    assign wbin_nx = wbin + 1'b1;
    assign rbin_nx = rbin + 1'b1;

    // Write side: full when write pointer is one lap ahead of synced read pointer.
    always_comb begin
        full     = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
        wr_level = wbin - g2b(rgray_w);
        wflag_n  = (mode_w == MODE_FWFT) ? full : ~full;
    end

    // Advance the write pointer on each accepted write.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Store the field of each accepted write.
    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wbin[AW-1:0]] <= din;
    end

    // Read side: decide when storage is popped into the output register.
    always_comb begin
        ram_empty = (rgray == wgray_r);
        if (mode_r == MODE_FWFT) take = (!ovalid || rd_en) && !ram_empty;
        else                     take = rd_en;
        rflag_n = (mode_r == MODE_FWFT) ? ~ovalid : ~ram_empty;
    end

    // Move the head word into the output register and track its validity.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rbin   <= '0;
            rgray  <= '0;
            q      <= '0;
            ovalid <= 1'b0;
        end else begin
            if (take) begin
                q     <= mem[rbin[AW-1:0]];
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
            end
            if (mode_r == MODE_FWFT) begin
                if (take)       ovalid <= 1'b1;
                else if (rd_en) ovalid <= 1'b0;
            end else begin
                ovalid <= 1'b0;
            end
        end
    end

    // R3: the composite flag must stop writes before this slice overflows.
    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_en |-> !full);

    // R4: the composite flag must stop reads before this slice underflows.
    p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_en |-> ((mode_r == MODE_FWFT) ? ovalid : !ram_empty));

    // R11: pointers crossing domains change by at most one bit per edge.
    p_wgray_step_r11: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    p_rgray_step_r11: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/wide_fifo.sv
// Width-expanded FIFO: NSL slices side by side, each holding one field.
// Slice widths come packed 8 bits each in SLICE_W_LIST (slice 0 lowest).
// SLICE_LAG gives each slice 0 or 1 extra synchronizer stages.
// Assumes rst_n is held low for several edges of both clocks.
module wide_fifo
    import wide_fifo_pkg::*;
#(
    parameter int               NSL          = 3,
    parameter logic [NSL*8-1:0] SLICE_W_LIST = {8'd12, 8'd10, 8'd8},
    parameter int               AW           = 4,
    parameter logic [NSL-1:0]   SLICE_LAG    = 3'b010,
    localparam int              DW           = field_lo(256'(SLICE_W_LIST), NSL)
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] din,
    input  logic          rd_en,
    output logic [DW-1:0] dout,
    output logic          full_ir_n,
    output logic          empty_or_n,
    output logic          half_n
);
    localparam int DEPTH = 1 << AW;

    fifo_mode_e     mode_w, mode_r;
    logic [NSL-1:0] wflags_n, rflags_n;
    logic [AW:0]    level_all [NSL];
    logic           wr_room, rd_data, wr_go, rd_go;

    // Capture the mode in the write domain while reset is held.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) mode_w <= fwft_sel ? MODE_FWFT : MODE_STD;
    end

    // Capture the mode in the read domain while reset is held.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) mode_r <= fwft_sel ? MODE_FWFT : MODE_STD;
    end

    wide_fifo_flag_merge #(.N(NSL)) u_wmerge (
        .mode(mode_w), .flags_n(wflags_n), .merged_n(full_ir_n)
    );

    wide_fifo_flag_merge #(.N(NSL)) u_rmerge (
        .mode(mode_r), .flags_n(rflags_n), .merged_n(empty_or_n)
    );

    // Gate the shared strobes with the composite readiness.
    always_comb begin
        wr_room = (mode_w == MODE_FWFT) ? !full_ir_n : full_ir_n;
        rd_data = (mode_r == MODE_FWFT) ? !empty_or_n : empty_or_n;
        wr_go   = wr_en && wr_room;
        rd_go   = rd_en && rd_data;
        half_n  = !(level_all[0] > (AW+1)'(DEPTH / 2));
    end

    for (genvar i = 0; i < NSL; i++) begin : g_slice
        localparam int LO = field_lo(256'(SLICE_W_LIST), i);
        localparam int WI = int'(SLICE_W_LIST[i*8 +: 8]);

        wide_fifo_slice #(.W(WI), .AW(AW), .LAG(int'(SLICE_LAG[i]))) u_slice (
            .wr_clk  (wr_clk),
            .rd_clk  (rd_clk),
            .rst_n   (rst_n),
            .mode_w  (mode_w),
            .mode_r  (mode_r),
            .wr_en   (wr_go),
            .din     (din[LO +: WI]),
            .rd_en   (rd_go),
            .q       (dout[LO +: WI]),
            .wflag_n (wflags_n[i]),
            .rflag_n (rflags_n[i]),
            .wr_level(level_all[i])
        );

        // R9: no slice ever holds more words than its storage.
        p_level_cap_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
            level_all[i] <= (AW+1)'(DEPTH));
    end

    // R2: the mode stays fixed once reset is released.
    p_mode_hold_w_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_w));

    p_mode_hold_r_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_r));

    // R1: first read-side cycle after reset reports no data.
    p_reset_empty_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $past(!rst_n) |-> (empty_or_n == (mode_r == MODE_FWFT)));

    // R4: in standard mode the output only moves on a taken read.
    p_dout_hold_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (mode_r == MODE_STD && !rd_go) |=> $stable(dout));

endmodule

// File: tb/wide_fifo_test.sv
module wide_fifo_test;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int DW    = 30;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          rst_n = 1'b0, fwft_sel = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          full_ir_n, empty_or_n, half_n;

    wide_fifo uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_sel(fwft_sel),
        .wr_en(wr_en), .din(din), .rd_en(rd_en), .dout(dout),
        .full_ir_n(full_ir_n), .empty_or_n(empty_or_n), .half_n(half_n)
    );

    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #4 rd_clk = ~rd_clk;
    end

    int            n_chk = 0, n_fail = 0;
    bit            done = 0, active = 0, cur_fwft = 0, pending = 0;
    int            wr_pct = 0, rd_pct = 0;
    logic [15:0]   tag = 0;
    logic [DW-1:0] model [$];
    logic [DW-1:0] exp_word = '0, held = '0;

    // R7: field i of a word is derived from one tag, so a torn word cannot match.
    function automatic logic [DW-1:0] make_word(input logic [15:0] t);
        return {12'(t * 3 + 2), 10'(t * 5 + 1), 8'(t)};
    endfunction

    function automatic int cap();
        return cur_fwft ? DEPTH + 1 : DEPTH;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Writer: decide one request per write cycle, mirror accepted words (R3).
    initial forever begin
        bit room, go;
        @(negedge wr_clk);
        room = cur_fwft ? !full_ir_n : full_ir_n;
        if (active && room)
            chk(model.size() < cap(), "R3", "room shown at capacity", model.size(), cap());
        go    = active && ($urandom_range(99) < wr_pct);
        wr_en = go;
        din   = make_word(tag);
        tag   = tag + 1;
        if (go && room) model.push_back(din);
    end

    // Reader: judge output data and flag claims, then decide one read (R4, R7, R8).
    initial forever begin
        bit has, go;
        @(negedge rd_clk);
        if (!active) begin
            rd_en   = 1'b0;
            pending = 0;
        end else begin
            if (!cur_fwft) begin
                if (pending) chk(dout == exp_word, "R8/R7", "std read word", dout, exp_word);
                else         chk(dout == held, "R4", "dout held without read", dout, held);
                held    = dout;
                pending = 0;
            end
            has = cur_fwft ? !empty_or_n : empty_or_n;
            if (has)
                chk(model.size() > 0, cur_fwft ? "R6" : "R5", "data shown while empty", 1, 0);
            if (has && cur_fwft && model.size() > 0)
                chk(dout == model[0], "R8/R7", "fall-through head word", dout, model[0]);
            go    = ($urandom_range(99) < rd_pct);
            rd_en = go;
            if (go && has && model.size() > 0) begin
                if (cur_fwft) void'(model.pop_front());
                else begin
                    exp_word = model.pop_front();
                    pending  = 1;
                end
            end
        end
    end

    task automatic set_rates(input int w, input int r);
        @(posedge wr_clk);
        wr_pct = w;
        rd_pct = r;
    endtask

    task automatic do_reset(input bit m);
        active = 0;
        wr_pct = 0;
        rd_pct = 0;
        @(negedge wr_clk);
        rst_n    = 1'b0;
        fwft_sel = m;
        repeat (6) @(negedge wr_clk);
        model.delete();
        held     = '0;
        cur_fwft = m;
        rst_n    = 1'b1;
        repeat (2) @(negedge wr_clk);
        @(negedge rd_clk);
        // R1: empty buffer flags after reset
        chk(empty_or_n == m, "R1", "read flag after reset", empty_or_n, m);
        chk(full_ir_n == !m, "R1", "write flag after reset", full_ir_n, !m);
        chk(half_n == 1'b1, "R1", "half flag after reset", half_n, 1);
        chk(dout == '0, "R1", "dout after reset", dout, 0);
        active = 1;
    endtask

    // Stop traffic, let flags cross, compare to the model count (R5, R6, R9, R10, R11).
    task automatic settle(input string where);
        int cnt, ram;
        set_rates(0, 0);
        repeat (14) @(negedge wr_clk);
        @(negedge rd_clk);
        cnt = model.size();
        ram = cur_fwft ? (cnt > 0 ? cnt - 1 : 0) : cnt;
        if (cur_fwft) begin
            chk(empty_or_n == (cnt == 0), "R6/R11", {where, " output-ready"}, empty_or_n, cnt == 0);
            chk(full_ir_n == (cnt == DEPTH + 1), "R6/R11", {where, " input-ready"}, full_ir_n, cnt == DEPTH + 1);
        end else begin
            chk(empty_or_n == (cnt != 0), "R5/R11", {where, " empty flag"}, empty_or_n, cnt != 0);
            chk(full_ir_n == (cnt != DEPTH), "R5/R11", {where, " full flag"}, full_ir_n, cnt != DEPTH);
        end
        chk(half_n == !(ram > DEPTH / 2), "R10", {where, " half flag"}, half_n, !(ram > DEPTH / 2));
    endtask

    task automatic run_mode(input bit m);
        logic [DW-1:0] first;
        do_reset(m);
        if (!m) fwft_sel = 1'b1;   // R2: late change must be ignored
        first = make_word(tag + 16'd1);
        set_rates(100, 0);
        set_rates(0, 0);
        settle("one word");
        if (!m) begin
            chk(dout == '0, "R2", "std mode kept after late select", dout, 0);
        end else begin
            chk(model.size() == 1, "R8", "one word accepted", model.size(), 1);
            chk(dout == model[0], "R8", "head word without read", dout, model[0]);
        end
        if (model.size() == 1) first = model[0];
        // Fill beyond capacity: extra writes are refused (R3, R9).
        set_rates(100, 0);
        repeat (DEPTH + 8) @(negedge wr_clk);
        settle("filled");
        chk(model.size() == cap(), "R9", "words accepted when filled", model.size(), cap());
        chk(model[0] == first, "R3", "oldest word kept", model[0], first);
        // Write and read together from full.
        set_rates(100, 100);
        repeat (40) @(negedge wr_clk);
        settle("full with both");
        // Drain past empty: extra reads refused (R4).
        set_rates(0, 100);
        repeat (DEPTH + 10) @(negedge rd_clk);
        settle("drained");
        chk(model.size() == 0, "R4", "all words read back", model.size(), 0);
        // Write and read together from empty.
        set_rates(100, 100);
        repeat (40) @(negedge wr_clk);
        settle("empty with both");
        // Random mixes.
        set_rates(70, 30); repeat (800) @(negedge wr_clk); settle("write heavy");
        set_rates(30, 70); repeat (800) @(negedge wr_clk); settle("read heavy");
        set_rates(50, 50); repeat (800) @(negedge wr_clk); settle("balanced");
        set_rates(0, 100);
        repeat (DEPTH + 10) @(negedge rd_clk);
        settle("final drain");
        chk(model.size() == 0, "R7", "every word returned in order", model.size(), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed1234));
        run_mode(1'b0);
        run_mode(1'b1);
        active = 0;
        done   = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule